// File: doc/BRIEF.md
# Transmit Command Parser with Trailing Pad Removal

This block takes 32-bit words from a host write port and turns them into a byte stream for a transmitter. Each buffer the host loads starts with two command words, the first describing the buffer's byte layout and the second carrying a tag and the packet length. Payload words follow. The host may add whole pad words after the real data so that every buffer ends on a burst-sized boundary. The block reads the commands, sends only the bytes the first command describes, and throws away the leading offset bytes and the trailing pad.

The host reads the free space in the word store before it writes. A write that arrives while the store is full is dropped and sets a sticky error flag. When the transmitter reports that a buffer has finished, whether it succeeded or failed, the block builds a status word from that buffer's command fields and the result, and pushes it into a small status queue for the host to read. A per-buffer completion interrupt can be requested in the first command. A second interrupt shows when enough status words are waiting.

Top module: `txs_cmd_strip`

## Requirements
- R1: The first word stored for a buffer is command A and the second is command B. Payload words follow, and the next buffer's command A comes directly after the last pad word of the previous buffer.
- R2: Command A holds the byte count in bits 10:0 and the start offset in bits 20:16. The block outputs exactly the count bytes found at byte addresses offset to offset+count-1 of the payload, where byte address 4k+j is bits 8j+7:8j of payload word k. `out_last` is high only with the final byte.
- R3: Command A bits 25:24 select the end boundary: 0 and 3 give 4 bytes, 1 gives 16 bytes, 2 gives 32 bytes. The block consumes exactly ceil((offset+count)/boundary)*boundary/4 payload words for the buffer. A buffer with offset 0 and count 0 consumes no payload words.
- R4: `free_words` equals the store depth minus the number of words held. It reads the full depth after reset.
- R5: A write while `free_words` is 0 is not stored and leaves the stored data intact. It sets `txerr`, which stays set until `txerr_clr` is driven to 1. `txerr` is 0 after reset.
- R6: A `done_valid` pulse while at least one parsed buffer waits for completion pushes a status word: bits 31:16 hold command B bits 31:16 (the tag), bit 15 holds `done_err`, bits 14:11 are zero, and bits 10:0 hold command B bits 10:0 (the packet length). A pulse with no buffer waiting is ignored. Completions match buffers in the order the buffers were parsed.
- R7: When command A bit 31 is set, `ioc_irq` is high for exactly the one cycle after that buffer's completion. It stays low when the bit is clear.
- R8: `stat_irq` is high while `stat_thresh` is nonzero and `stat_level` is at least `stat_thresh`.
- R9: A status word produced while the status queue is full is dropped. The entries already queued are kept in order.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Host word write strobe |
| wr_data | input | 32 | Host word |
| free_words | output | $clog2(DATA_DEPTH)+1 | Free word slots in the store |
| txerr | output | 1 | Sticky overfill flag |
| txerr_clr | input | 1 | Write 1 to clear `txerr` |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the buffer |
| out_ready | input | 1 | Transmitter accepts the byte |
| done_valid | input | 1 | Transmitter finished the oldest buffer |
| done_err | input | 1 | That send failed |
| ioc_irq | output | 1 | Per-buffer completion interrupt pulse |
| stat_rd | input | 1 | Pop the head status word |
| stat_data | output | 32 | Head status word |
| stat_level | output | $clog2(STAT_DEPTH)+1 | Status words waiting |
| stat_thresh | input | $clog2(STAT_DEPTH)+1 | Status interrupt threshold, 0 disables |
| stat_irq | output | 1 | Status level interrupt |

## Verification
The bench builds the block with an 8-word store, a 4-entry status queue and the default 4-entry completion queue. With the 8-word store, a single 32-byte buffer fills the store while the output is held back, so the overfill path, the full-store free count and the output hold can all be seen in one directed test. With the 4-entry status queue, five completions are enough to overflow the queue and show that the extra status is dropped. A 3-bit threshold can then sit just below and at the level. The table-driven part covers every boundary code, including the reserved one, as well as offsets of zero, one and thirty-one bytes, an already aligned buffer and an empty buffer.

// File: rtl/txs_pkg.sv
// Shared types and helpers for the transmit command parser.
// Assumes the command field layout given in the brief (R2, R3, R6).
package txs_pkg;

    localparam int unsigned CNT_W  = 11;
    localparam int unsigned OFF_W  = 5;
    localparam int unsigned TAG_W  = 16;
    localparam int unsigned ADDR_W = 13;

    typedef enum logic [1:0] {
        PS_CMDA = 2'd0,
        PS_CMDB = 2'd1,
        PS_PAY  = 2'd2
    } ps_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [CNT_W-1:0] len;
        logic             ioc;
    } meta_t;

    // Round a byte end address up to the boundary chosen by the 2-bit code.
    function automatic logic [ADDR_W-1:0] align_end(input logic [ADDR_W-1:0] e,
                                                    input logic [1:0] code);
        logic [ADDR_W-1:0] m;
        case (code)
            2'd1:    m = ADDR_W'(15);
            2'd2:    m = ADDR_W'(31);
            default: m = ADDR_W'(3);
        endcase
        return (e + m) & ~m;
    endfunction

endpackage

// File: rtl/txs_fifo.sv
// Synchronous first-in first-out store with a show-ahead head word.
// Assumes DEPTH is a power of two. A push while full and a pop while empty are ignored,
// so stored entries are never overwritten.
module txs_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  pdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rp];

    // Storage write; array holds no reset state.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= pdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/txs_parser.sv
// Reads command A, command B and payload words from the word store, emits the real
// payload bytes one per cycle and skips offset and pad bytes without output.
// Assumes the store presents its head word combinationally and that the completion
// queue only drains while a buffer is being parsed.
module txs_parser
    import txs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_empty,
    input  logic [31:0] fifo_head,
    output logic        fifo_pop,
    input  logic        meta_full,
    output logic        meta_push,
    output meta_t       meta_data,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    input  logic        out_ready
);
    ps_e               state;
    logic [CNT_W-1:0]  cnt_r;
    logic [OFF_W-1:0]  off_r;
    logic [1:0]        aln_r;
    logic              ioc_r;
    logic [TAG_W-1:0]  tag_r;
    logic [CNT_W-1:0]  len_r;
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] end_c, aend_c;
    logic              in_rng, step, at_end, take_b;
    logic              unused_bits;

    assign unused_bits = ^{fifo_head[15:11], fifo_head[23:21], fifo_head[30:26]};

    // Buffer geometry derived from the latched command A fields.
    always_comb begin
        end_c  = ADDR_W'(off_r) + ADDR_W'(cnt_r);
        aend_c = align_end(end_c, aln_r);
        in_rng = (addr >= ADDR_W'(off_r)) && (addr < end_c);
        at_end = ((addr + ADDR_W'(1)) == aend_c);
        take_b = (state == PS_CMDB) && !fifo_empty && !meta_full;
        step   = (state == PS_PAY) && !fifo_empty && (!in_rng || out_ready);
    end

    // Handshake outputs toward the store, the completion queue and the transmitter.
    always_comb begin
        out_valid = (state == PS_PAY) && !fifo_empty && in_rng;
        out_data  = fifo_head[{addr[1:0], 3'b000} +: 8];
        out_last  = out_valid && ((addr + ADDR_W'(1)) == end_c);
        fifo_pop  = ((state == PS_CMDA) && !fifo_empty) || take_b
                  || (step && (addr[1:0] == 2'd3));
        meta_push = (take_b && (aend_c == '0)) || (step && at_end);
        meta_data.tag = (state == PS_CMDB) ? fifo_head[31:16] : tag_r;
        meta_data.len = (state == PS_CMDB) ? fifo_head[10:0]  : len_r;
        meta_data.ioc = ioc_r;
    end

    // Command and payload walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_CMDA;
            cnt_r <= '0;
            off_r <= '0;
            aln_r <= '0;
            ioc_r <= 1'b0;
            tag_r <= '0;
            len_r <= '0;
            addr  <= '0;
        end else begin
            case (state)
                PS_CMDA: if (!fifo_empty) begin
                    cnt_r <= fifo_head[10:0];
                    off_r <= fifo_head[20:16];
                    aln_r <= fifo_head[25:24];
                    ioc_r <= fifo_head[31];
                    state <= PS_CMDB;
                end
                PS_CMDB: if (take_b) begin
                    tag_r <= fifo_head[31:16];
                    len_r <= fifo_head[10:0];
                    addr  <= '0;
                    state <= (aend_c == '0) ? PS_CMDA : PS_PAY;
                end
                PS_PAY: if (step) begin
                    addr <= addr + ADDR_W'(1);
                    if (at_end) state <= PS_CMDA;
                end
                default: state <= PS_CMDA;
            endcase
        end
    end

    // R10: a stalled byte stays put until accepted.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R1: words are only taken from a store that has them.
    assert_pop_nonempty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    // R3: the end of a payload walk lands on a boundary multiple of 4 bytes.
    assert_word_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_end) |-> (addr[1:0] == 2'd3));

endmodule

// File: rtl/txs_cmd_strip.sv
// Top of the transmit command parser: host word store, parser, completion queue
// and status queue with interrupts.
// Assumes all depths are powers of two and that the transmitter completes buffers
// in the order it received them.
module txs_cmd_strip
    import txs_pkg::*;
#(
    parameter int unsigned DATA_DEPTH = 16,
    parameter int unsigned META_DEPTH = 4,
    parameter int unsigned STAT_DEPTH = 8,
    localparam int unsigned DCW = $clog2(DATA_DEPTH) + 1,
    localparam int unsigned MCW = $clog2(META_DEPTH) + 1,
    localparam int unsigned SCW = $clog2(STAT_DEPTH) + 1,
    localparam int unsigned MW  = $bits(meta_t)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_valid,
    input  logic [31:0]    wr_data,
    output logic [DCW-1:0] free_words,
    output logic           txerr,
    input  logic           txerr_clr,
    output logic           out_valid,
    output logic [7:0]     out_data,
    output logic           out_last,
    input  logic           out_ready,
    input  logic           done_valid,
    input  logic           done_err,
    output logic           ioc_irq,
    input  logic           stat_rd,
    output logic [31:0]    stat_data,
    output logic [SCW-1:0] stat_level,
    input  logic [SCW-1:0] stat_thresh,
    output logic           stat_irq
);
    logic [31:0]    data_head;
    logic [DCW-1:0] data_count;
    logic           data_full, data_pop;
    logic           meta_push, meta_full;
    logic [MCW-1:0] meta_count;
    meta_t          meta_in, meta_head;
    logic [MW-1:0]  meta_head_v;
    logic           stat_push, stat_full;
    logic [31:0]    stat_word;

    txs_fifo #(.W(32), .DEPTH(DATA_DEPTH)) u_data (
        .clk(clk), .rst_n(rst_n),
        .push(wr_valid), .pdata(wr_data), .pop(data_pop),
        .head(data_head), .count(data_count), .full(data_full)
    );

    txs_parser u_parse (
        .clk(clk), .rst_n(rst_n),
        .fifo_empty(data_count == '0), .fifo_head(data_head), .fifo_pop(data_pop),
        .meta_full(meta_full), .meta_push(meta_push), .meta_data(meta_in),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready)
    );

    txs_fifo #(.W(MW), .DEPTH(META_DEPTH)) u_meta (
        .clk(clk), .rst_n(rst_n),
        .push(meta_push), .pdata(meta_in), .pop(stat_push),
        .head(meta_head_v), .count(meta_count), .full(meta_full)
    );

    txs_fifo #(.W(32), .DEPTH(STAT_DEPTH)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .push(stat_push), .pdata(stat_word), .pop(stat_rd),
        .head(stat_data), .count(stat_level), .full(stat_full)
    );

    // Completion pairing and status word assembly.
    always_comb begin
        meta_head  = meta_t'(meta_head_v);
        stat_push  = done_valid && (meta_count != '0);
        stat_word  = {meta_head.tag, done_err, 4'b0000, meta_head.len};
        free_words = DCW'(DATA_DEPTH) - data_count;
        stat_irq   = (stat_thresh != '0) && (stat_level >= stat_thresh);
    end

    // Sticky overfill flag and completion interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txerr   <= 1'b0;
            ioc_irq <= 1'b0;
        end else begin
            if (wr_valid && data_full) txerr <= 1'b1;
            else if (txerr_clr)        txerr <= 1'b0;
            ioc_irq <= stat_push && meta_head.ioc;
        end
    end

    assert_overfill_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && data_full) |=> txerr);

    assert_free_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !data_full && !data_pop) |=> (free_words == $past(free_words) - DCW'(1)));

    assert_status_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_push && !stat_full && !stat_rd) |=> (stat_level == $past(stat_level) + SCW'(1)));

    assert_ioc_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ioc_irq |-> $past(stat_push));

    assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_irq |-> (stat_level != '0));

    assert_drop_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_push && stat_full && !stat_rd) |=> stat_full);

endmodule

// File: tb/txs_cmd_strip_tb.sv
`timescale 1ns/1ps
module txs_cmd_strip_tb;
    localparam int DD  = 8;
    localparam int SD  = 4;
    localparam int DCW = $clog2(DD) + 1;
    localparam int SCW = $clog2(SD) + 1;
    localparam int NV  = 7;

    // Vector table: command A and command B per buffer.
    localparam logic [31:0] VA [NV] = '{32'h8000_0007, 32'h0103_0005, 32'h8201_0014,
                                        32'h0100_0010, 32'h8302_0003, 32'h021F_0001,
                                        32'h8000_0000};
    localparam logic [31:0] VB [NV] = '{32'h1111_0007, 32'h2222_0005, 32'h3333_0014,
                                        32'h4444_0010, 32'h5555_0003, 32'h6666_0001,
                                        32'h7777_0000};

    logic clk = 1'b0;
    logic rst_n, wr_valid, txerr_clr, out_ready, done_valid, done_err, stat_rd;
    logic [31:0] wr_data, stat_data;
    logic [DCW-1:0] free_words;
    logic [SCW-1:0] stat_level, stat_thresh;
    logic txerr, out_valid, out_last, ioc_irq, stat_irq;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] cap [64];
    bit caplast [64];
    int ncap = 0;

    always #4 clk = ~clk;

    txs_cmd_strip #(.DATA_DEPTH(DD), .META_DEPTH(4), .STAT_DEPTH(SD)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .free_words(free_words), .txerr(txerr), .txerr_clr(txerr_clr),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .done_valid(done_valid), .done_err(done_err),
        .ioc_irq(ioc_irq), .stat_rd(stat_rd), .stat_data(stat_data),
        .stat_level(stat_level), .stat_thresh(stat_thresh), .stat_irq(stat_irq)
    );

    // Byte collector, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && ncap < 64) begin
            cap[ncap] = out_data;
            caplast[ncap] = out_last;
            ncap++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int v, input int a);
        return 8'((a * 7 + v * 29 + 3) & 255);
    endfunction

    function automatic logic [31:0] pword(input int v, input int w);
        return {pat(v, 4*w+3), pat(v, 4*w+2), pat(v, 4*w+1), pat(v, 4*w)};
    endfunction

    function automatic int aligned_end(input logic [31:0] a);
        int al, e;
        al = (a[25:24] == 2'd1) ? 16 : (a[25:24] == 2'd2) ? 32 : 4;
        e  = int'(a[20:16]) + int'(a[10:0]);
        return ((e + al - 1) / al) * al;
    endfunction

    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        while (free_words == 0) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic write_force(input logic [31:0] w);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic write_buffer(input logic [31:0] a, input logic [31:0] b, input int v);
        write_word(a);
        write_word(b);
        for (int w = 0; w < aligned_end(a) / 4; w++) write_word(pword(v, w));
    endtask

    task automatic complete(input bit err);
        @(negedge clk);
        done_valid = 1'b1;
        done_err   = err;
        @(negedge clk);
        done_valid = 1'b0;
        done_err   = 1'b0;
    endtask

    task automatic pop_status();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic check_bytes(input int v, input logic [31:0] a, input string req);
        int bad = 0;
        int cnt = int'(a[10:0]);
        int off = int'(a[20:16]);
        check(ncap == cnt, {req, " byte count"}, ncap, cnt);
        for (int i = 0; i < cnt && i < ncap; i++) begin
            if (cap[i] != pat(v, off + i) || caplast[i] != (i == cnt - 1)) bad++;
        end
        check(bad == 0, {req, " byte values and last flag"}, bad, 0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; txerr_clr = 1'b0;
        out_ready = 1'b1; done_valid = 1'b0; done_err = 1'b0; stat_rd = 1'b0;
        stat_thresh = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state.
        check(free_words == DD, "R4 reset free space", free_words, DD);
        check(txerr == 1'b0, "R5 reset error flag", txerr, 0);
        check(out_valid == 1'b0 && stat_level == 0 && ioc_irq == 1'b0 && stat_irq == 1'b0,
              "R6 reset outputs idle", {out_valid, stat_level, ioc_irq, stat_irq}, 0);

        // Completion with nothing outstanding is ignored (R6).
        complete(1'b1);
        check(stat_level == 0, "R6 stray completion ignored", stat_level, 0);
        check(ioc_irq == 1'b0, "R7 no pulse on stray completion", ioc_irq, 0);

        // Table walk: byte extraction, pad removal, status and interrupt.
        for (int v = 0; v < NV; v++) begin
            logic [31:0] expst;
            ncap = 0;
            write_buffer(VA[v], VB[v], v);
            repeat (60) @(negedge clk);
            check_bytes(v, VA[v], "R1/R2");
            check(free_words == DD, "R3 pad words consumed", free_words, DD);
            complete(v[0]);
            expst = {VB[v][31:16], v[0], 4'b0000, VB[v][10:0]};
            check(ioc_irq == VA[v][31], "R7 completion pulse", ioc_irq, VA[v][31]);
            check(stat_level == 1, "R6 status pushed", stat_level, 1);
            check(stat_data == expst, "R6 status word", stat_data, expst);
            @(negedge clk);
            check(ioc_irq == 1'b0, "R7 pulse lasts one cycle", ioc_irq, 0);
            pop_status();
            check(stat_level == 0, "R6 status popped", stat_level, 0);
        end

        // Overfill while the output is held back.
        out_ready = 1'b0;
        ncap = 0;
        write_buffer(32'h0000_0020, 32'hABCD_0020, 9);
        repeat (5) @(negedge clk);
        check(free_words == 0, "R4 store full", free_words, 0);
        check(out_valid == 1'b1 && out_data == pat(9, 0), "R10 stalled byte shown",
              {out_valid, out_data}, {1'b1, pat(9, 0)});
        write_force(32'hDEAD_BEEF);
        check(txerr == 1'b1, "R5 overfill sets flag", txerr, 1);
        repeat (4) @(negedge clk);
        check(out_valid == 1'b1 && out_data == pat(9, 0), "R10 byte held under stall",
              {out_valid, out_data}, {1'b1, pat(9, 0)});
        check(free_words == 0, "R5 dropped word not stored", free_words, 0);
        out_ready = 1'b1;
        repeat (60) @(negedge clk);
        check_bytes(9, 32'h0000_0020, "R5 data intact after overfill");
        check(free_words == DD, "R5 store drained", free_words, DD);
        check(txerr == 1'b1, "R5 flag sticky", txerr, 1);
        txerr_clr = 1'b1;
        @(negedge clk);
        txerr_clr = 1'b0;
        check(txerr == 1'b0, "R5 flag cleared", txerr, 0);
        complete(1'b0);
        pop_status();

        // Status threshold interrupt.
        stat_thresh = SCW'(3);
        for (int k = 0; k < 3; k++) write_buffer(32'h0000_0004, {16'h00B0 + 16'(k), 16'h0004}, k);
        repeat (20) @(negedge clk);
        complete(1'b0);
        complete(1'b0);
        check(stat_irq == 1'b0, "R8 below threshold", stat_irq, 0);
        complete(1'b0);
        check(stat_irq == 1'b1, "R8 at threshold", stat_irq, 1);
        pop_status();
        check(stat_irq == 1'b0, "R8 drops after pop", stat_irq, 0);
        pop_status();
        pop_status();
        stat_thresh = '0;

        // Status queue full: the fifth status is dropped.
        for (int k = 0; k < 5; k++) begin
            write_buffer(32'h0000_0004, {16'h00A0 + 16'(k), 16'h0004}, k);
            repeat (10) @(negedge clk);
            complete(1'b0);
        end
        check(stat_level == SD, "R9 queue holds depth", stat_level, SD);
        for (int k = 0; k < SD; k++) begin
            logic [31:0] e;
            e = {16'h00A0 + 16'(k), 16'h0004};
            check(stat_data == e, "R9 queued order kept", stat_data, e);
            pop_status();
        end
        check(stat_level == 0, "R9 extra status dropped", stat_level, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule